// File: doc/BRIEF.md
# Pipelined Burst SRAM with Dual Address Strobes

This block is a small synthesizable model of a synchronous static memory. It is addressed through two address strobes, one for a processor and one for a controller, and it moves data in short linear bursts. Each word is 36 bits wide and is split into four 9-bit lanes. Each lane holds eight data bits and one parity bit. Every control input is sampled on the rising clock edge. The exception is the output enable, which gates the read port combinationally.

A strobe that is accepted captures a new address and starts a burst. On the edges that follow, the advance input steps a 2-bit counter through the four words of the aligned group, wrapping at the end. The three chip enables are evaluated only on a load edge; the select state they produce is held until the next load. Writes can cover all four lanes at once or only chosen lanes. Reads pass through one output register. The first read after a deselected period is suppressed at the port. The bidirectional bus is modelled as separate input and output ports, plus a valid flag.

Top module: `sync_burst_sram`

## Requirements
- R1: After reset the memory is deselected, `dout_vld` is low and `dout` is zero.
- R2: On an accepted strobe edge, `addr` is captured and its two low bits seed the burst counter. The processor strobe is accepted only when `sel1_n` is low. The controller strobe is acted on whenever it is low and the processor strobe is not accepted.
- R3: When both strobes are low and `sel1_n` is low, the processor strobe wins. That edge is always a read, and the write controls are ignored on it.
- R4: The select state becomes `!sel1_n && sel2 && !sel3_n`, evaluated only on load edges. Chip-enable values on other edges have no effect. While deselected, no write lands and no read reaches the port.
- R5: While selected, an edge without a strobe accesses the next word if `adv_n` is low. The counter steps 0,1,2,3,0 and the upper address bits stay fixed. With `adv_n` high, the same word is accessed again.
- R6: With `gw_n` low on a write-capable edge, all four lanes are written, whatever `bw_n` and `lane_n` hold.
- R7: Without a global write, lane i (bits 9i+8 down to 9i, with the parity bit at the top) is written only when `bw_n` is low and `lane_n[i]` is low. An edge that writes no lane is a read.
- R8: A read samples the word at the edge that addressed it and presents it on `dout` just after that edge. It stays there until the next edge.
- R9: While `oe_n` is high, `dout_vld` is low and `dout` is zero. A change of `oe_n` acts immediately, without waiting for a clock edge.
- R10: A read on an edge where the memory was deselected beforehand does not raise `dout_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address |
| strobe_cpu_n | input | 1 | Processor address strobe, active low |
| strobe_ctl_n | input | 1 | Controller address strobe, active low |
| sel1_n | input | 1 | Chip enable, active low; also qualifies the processor strobe |
| sel2 | input | 1 | Chip enable, active high |
| sel3_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bw_n | input | 1 | Byte-write enable, active low |
| lane_n | input | LANES | Per-lane write selects, active low |
| oe_n | input | 1 | Output enable, asynchronous, active low |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Read data, zero when not valid |
| dout_vld | output | 1 | Read data valid on `dout` |

## Verification
A wrong select state or a wrong burst counter shows up at the port on the very next edge: either a word from a neighbouring address, or a missing or unexpected `dout_vld`. A write error stays hidden in the array until that word is read again. For this reason every write phase is followed by read-back of the affected addresses, and all sixteen lane-select patterns are applied to one word. A wrong mask flag shows up in the single cycle after a read that follows a deselect.

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
  parameter int ADDR_W = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    strobe_cpu_n,
  input  logic                    strobe_ctl_n,
  input  logic                    sel1_n,
  input  logic                    sel2,
  input  logic                    sel3_n,
  input  logic                    adv_n,
  input  logic                    gw_n,
  input  logic                    bw_n,
  input  logic [LANES-1:0]        lane_n,
  input  logic                    oe_n,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_vld
);
  localparam int DW    = LANES * LANE_W;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int UP_W  = ADDR_W - 2;

  logic [DW-1:0]   mem [DEPTH];
  logic            sel_q, rd_q, mask_q;
  logic [UP_W-1:0] up_q;
  logic [1:0]      cnt_q;
  logic [DW-1:0]   q_q;
  logic [LANES-1:0] we;

  wire cpu_take = !strobe_cpu_n && !sel1_n;
  wire load     = cpu_take || !strobe_ctl_n;
  wire ce_ok    = !sel1_n && sel2 && !sel3_n;
  wire active   = load ? ce_ok : sel_q;
  wire cnt_step = !load && sel_q && !adv_n;
  wire [ADDR_W-1:0] acc_addr = load ? addr : {up_q, cnt_step ? cnt_q + 2'd1 : cnt_q};

  always_comb begin
    if (!active || cpu_take) we = '0;
    else if (!gw_n)          we = '1;
    else if (!bw_n)          we = ~lane_n;
    else                     we = '0;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++)
      if (we[i]) mem[acc_addr][i*LANE_W +: LANE_W] <= din[i*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      rd_q   <= 1'b0;
      mask_q <= 1'b1;
      up_q   <= '0;
      cnt_q  <= '0;
      q_q    <= '0;
    end else begin
      if (load) begin
        sel_q <= ce_ok;
        up_q  <= addr[ADDR_W-1:2];
        cnt_q <= addr[1:0];
      end else if (cnt_step) begin
        cnt_q <= cnt_q + 2'd1;
      end
      rd_q   <= active && (we == '0);
      mask_q <= !sel_q;
      q_q    <= mem[acc_addr];
    end
  end

  assign dout_vld = rd_q && !mask_q && !oe_n;
  assign dout     = dout_vld ? q_q : '0;

  p_load_seeds_cnt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(addr[1:0])));

  p_sel_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(sel_q));

  p_upper_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(up_q));

  p_cnt_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_step |=> (cnt_q == 2'($past(cnt_q) + 2'd1)));

  p_cnt_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !cnt_step) |=> $stable(cnt_q));

  p_no_write_cpu_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_take |-> (we == '0));

  p_first_read_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dout_vld |-> $past(sel_q));
endmodule

// File: tb/sync_burst_sram_bench.sv
module sync_burst_sram_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic strobe_cpu_n = 1'b1, strobe_ctl_n = 1'b1;
  logic sel1_n = 1'b1, sel2 = 1'b0, sel3_n = 1'b1;
  logic adv_n = 1'b1, gw_n = 1'b1, bw_n = 1'b1, oe_n = 1'b0;
  logic [3:0]  lane_n = 4'hF;
  logic [35:0] din = '0;
  logic [35:0] dout;
  logic        dout_vld;

  int n_chk = 0, n_fail = 0;

  logic [35:0] ref_mem [16];
  bit          r_sel = 1'b0;
  logic [1:0]  r_up = '0, r_cnt = '0;

  always #4 clk = ~clk;

  sync_burst_sram u_sync_burst_sram (
    .clk(clk), .rst_n(rst_n), .addr(addr),
    .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n),
    .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
    .adv_n(adv_n), .gw_n(gw_n), .bw_n(bw_n), .lane_n(lane_n),
    .oe_n(oe_n), .din(din), .dout(dout), .dout_vld(dout_vld)
  );

  function automatic logic [35:0] pat(input int k);
    return 36'(k * 36'h1_3579_BDF1 + 36'h2_468A_CE0F);
  endfunction

  task automatic check(input logic v, input logic ev, input logic [35:0] d,
                       input logic [35:0] ed, input string tag);
    n_chk++;
    if (v !== ev || d !== ed) begin
      n_fail++;
      $display("FAIL %s: vld=%0b dout=%h expected vld=%0b dout=%h", tag, v, d, ev, ed);
    end
  endtask

  task automatic step(input bit cpu_n, ctl_n, s1n, s2, s3n, advn, gwn, bwn,
                      input logic [3:0] ln, input logic [3:0] a,
                      input logic [35:0] d, input string tag);
    bit take, ld, act, rd, first, ev;
    logic [3:0] ea, m;
    logic [35:0] ed;
    @(negedge clk);
    strobe_cpu_n = cpu_n; strobe_ctl_n = ctl_n;
    sel1_n = s1n; sel2 = s2; sel3_n = s3n; adv_n = advn;
    gw_n = gwn; bw_n = bwn; lane_n = ln; addr = a; din = d;
    take  = !cpu_n && !s1n;
    ld    = take || !ctl_n;
    act   = ld ? (!s1n && s2 && !s3n) : r_sel;
    ea    = ld ? a : {r_up, (r_sel && !advn) ? r_cnt + 2'd1 : r_cnt};
    m     = (!act || take) ? 4'h0 : (!gwn ? 4'hF : (!bwn ? ~ln : 4'h0));
    rd    = act && (m == 4'h0);
    first = !r_sel;
    ed    = ref_mem[ea];
    for (int i = 0; i < 4; i++)
      if (m[i]) ref_mem[ea][i*9 +: 9] = d[i*9 +: 9];
    if (ld) begin
      r_sel = !s1n && s2 && !s3n; r_up = a[3:2]; r_cnt = a[1:0];
    end else if (r_sel && !advn) begin
      r_cnt = r_cnt + 2'd1;
    end
    @(posedge clk); #1;
    ev = rd && !first && !oe_n;
    check(dout_vld, ev, dout, ev ? ed : 36'h0, tag);
  endtask

  task automatic nop(input string tag);
    step(1,1,1,0,1,1,1,1,4'hF,4'h0,36'h0,tag);
  endtask
  task automatic desel(input string tag);
    step(1,0,1,1,0,1,1,1,4'hF,4'h0,36'h0,tag);
  endtask
  task automatic rd_cpu(input logic [3:0] a, input string tag);
    step(0,1,0,1,0,1,1,1,4'hF,a,36'h0,tag);
  endtask
  task automatic acc_ctl(input logic [3:0] a, input bit gwn, bwn,
                         input logic [3:0] ln, input logic [35:0] d, input string tag);
    step(1,0,0,1,0,1,gwn,bwn,ln,a,d,tag);
  endtask
  task automatic adv(input bit gwn, bwn, input logic [3:0] ln,
                     input logic [35:0] d, input string tag);
    step(1,1,1,0,1,0,gwn,bwn,ln,4'h0,d,tag);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: vld=%0b dout=%h expected run to finish", dout_vld, dout);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) ref_mem[i] = 36'h0;
    repeat (3) @(posedge clk);
    #1 check(dout_vld, 1'b0, dout, 36'h0, "R1 reset");
    @(negedge clk) rst_n = 1'b1;

    // R6 and R5: fill every word with global-write bursts
    for (int b = 0; b < 4; b++) begin
      acc_ctl(4'(4*b), 1'b0, 1'b1, 4'hF, pat(4*b), "R6 burst start");
      for (int k = 1; k < 4; k++) adv(1'b0, 1'b1, 4'hF, pat(4*b+k), "R5 burst write");
    end

    // R10 and R5: masked first read, then wrap 6,7,4,5,6 and hold
    desel("R4 deselect");
    rd_cpu(4'd6, "R10 masked first read");
    for (int k = 0; k < 4; k++) adv(1'b1, 1'b1, 4'hF, 36'h0, "R5 wrap read");
    nop("R5 hold address");

    // R9: asynchronous output enable
    @(negedge clk); oe_n = 1'b1; #1;
    check(dout_vld, 1'b0, dout, 36'h0, "R9 oe high");
    oe_n = 1'b0; #1;
    check(dout_vld, 1'b1, dout, pat(6), "R9 oe low");
    @(negedge clk); oe_n = 1'b1;
    nop("R9 read with oe high");
    @(negedge clk); oe_n = 1'b0;

    // R4: writes while deselected are dropped
    desel("R4 deselect");
    adv(1'b0, 1'b1, 4'hF, 36'hF_FFFF_FFFF, "R4 write while deselected");
    nop("R4 no output while deselected");
    rd_cpu(4'd0, "R10 masked first read");
    nop("R4 word unchanged");
    // R4: chip enables ignored on non-load edges (adv passes deselect levels)
    adv(1'b1, 1'b1, 4'hF, 36'h0, "R4 enables ignored mid burst");

    // R3: both strobes low, cpu wins, no write
    step(0,0,0,1,0,1,0,0,4'h0,4'd3,36'hA_AAAA_AAAA,"R3 both strobes");
    nop("R3 word unchanged");
    // R2: cpu strobe with sel1_n high is ignored, ctl loads a deselect
    step(0,0,1,1,0,1,1,1,4'hF,4'd5,36'h0,"R2 ctl takes over");
    nop("R2 deselected after ctl load");
    rd_cpu(4'd5, "R2 cpu load");
    adv(1'b1, 1'b1, 4'hF, 36'h0, "R2 counter seeded");

    // R7: every lane pattern on one word
    for (int p = 0; p < 16; p++) begin
      acc_ctl(4'd9, 1'b1, 1'b0, 4'(p), pat(100+p), "R7 byte write");
      nop("R7 merge readback");
    end
    acc_ctl(4'd10, 1'b1, 1'b1, 4'h0, pat(200), "R7 selects without enable");
    nop("R7 no lane written");
    acc_ctl(4'd11, 1'b0, 1'b0, 4'hF, pat(300), "R6 global override");
    nop("R6 all lanes written");

    // R8: sweep every address
    for (int a = 0; a < 16; a++) acc_ctl(4'(a), 1'b1, 1'b1, 4'hF, 36'h0, "R8 read latency");
    finish_run();
  end
endmodule